// File: doc/BRIEF.md
# Cartridge-Bus Byte DMA Engine

This block copies a run of bytes between main DRAM and the cartridge address space, in whichever direction software asks for. Software first loads a DRAM start address and a cartridge start address through a small register-write port. It then writes one of two length registers. The length register it writes picks the direction and starts the copy. The engine moves one byte per clock over a byte-wide read port on the source side and a byte-wide write port on the destination side. Both memories answer reads in the same cycle.

Once the last byte has moved, the engine waits for a latency count. That count is given on an input and sampled when the transfer starts. When the count expires, the engine drops its busy flag and pulses a completion interrupt for one cycle. It then leaves both address registers realigned for the next transfer: the DRAM address is moved up to an 8-byte boundary and the cartridge address to an even value. When the save-memory remap input is high, cartridge addresses inside the first 64 KiB of the save window starting at 0x0800_0000 are spread out to twice their offset before the copy begins.

Top module: `cbus_dma`

## Requirements
- R1: After reset, busy, the completion pulse and both memory write enables are low, and both address register outputs read zero.
- R2: A register write with select 0 loads the DRAM address from data bits DRAM_AW-1:2, with bits 1:0 cleared. A register write with select 1 loads the cartridge address from the data with bit 0 cleared.
- R3: A register write with select 2 takes data bits LEN_W-1:0 as a length L and starts a DRAM-to-cartridge copy of L+1 bytes. In the k-th cycle after the write edge (k = 0..L), the engine reads DRAM at start+k and writes that byte to the cartridge at start+k, with the cartridge write enable high.
- R4: A register write with select 3 starts a cartridge-to-DRAM copy in the same way, with the DRAM write enable high.
- R5: When a copy of N bytes completes, the DRAM address register becomes (start + N) rounded up to a multiple of 8, modulo 2^DRAM_AW.
- R6: When a copy of N bytes completes, the cartridge address register becomes the effective start + N, plus one more if that sum is odd.
- R7: When the remap input is high at the starting write and the cartridge address A satisfies 0x0800_0000 <= A < 0x0801_0000, the copy starts at 0x0800_0000 | (A[19:0] << 1). Otherwise it starts at A.
- R8: Busy is high from the cycle after the starting write until the completion pulse. With N bytes and latency input T sampled at the starting write, the one-cycle completion pulse is seen N+T+1 cycles after the write edge, and busy is low in that same cycle. Later changes to T have no effect.
- R9: Every register write is ignored while busy is high. It neither starts a copy nor changes an address register.
- R10: At most one write enable is high in any cycle, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 DRAM address, 1 cart address, 2 DRAM-to-cart length, 3 cart-to-DRAM length |
| reg_wdata | input | 32 | Register write data |
| flash_remap_en | input | 1 | Enables the save-window address remap |
| lat_cycles | input | LAT_W | Completion latency, sampled at the starting write |
| dram_rd_addr | output | DRAM_AW | DRAM read address |
| dram_rd_data | input | 8 | DRAM read data, same cycle |
| dram_wr_en | output | 1 | DRAM byte write enable |
| dram_wr_addr | output | DRAM_AW | DRAM write address |
| dram_wr_data | output | 8 | DRAM write data |
| cart_rd_addr | output | CART_AW | Cartridge read address |
| cart_rd_data | input | 8 | Cartridge read data, same cycle |
| cart_wr_en | output | 1 | Cartridge byte write enable |
| cart_wr_addr | output | CART_AW | Cartridge write address |
| cart_wr_data | output | 8 | Cartridge write data |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| dram_addr_o | output | DRAM_AW | Current DRAM address register |
| cart_addr_o | output | CART_AW | Current cartridge address register |

## Verification
The bench builds the block with DRAM_AW=16, LEN_W=8 and LAT_W=4, and keeps CART_AW at 32 so that the save window stays in place. With a 16-bit DRAM space, start addresses just below the top wrap within a short copy, so the modulo rounding of R5 is exercised as well as the odd-sum correction of R6. The 4-bit latency lets the sweep cover both directions, several lengths up to 41 bytes and latencies from 0 to 15. The cartridge addresses placed on and just outside the edges of the save window test the remap bounds.

// File: rtl/cbus_dma_pkg.sv
package cbus_dma_pkg;

    // Register select codes on the write port
    typedef enum logic [1:0] {
        SEL_DRAM_ADDR = 2'd0,
        SEL_CART_ADDR = 2'd1,
        SEL_TO_CART   = 2'd2,
        SEL_TO_DRAM   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/cbus_dma_regs.sv
module cbus_dma_regs
    import cbus_dma_pkg::*;
#(
    parameter int                DRAM_AW   = 24,
    parameter int                CART_AW   = 32,
    parameter int                LEN_W     = 24,
    parameter int                ALIGN_LG2 = 3,
    parameter int                WIN_OFS_W = 20,
    parameter logic [CART_AW-1:0] WIN_LO   = CART_AW'(32'h0800_0000),
    parameter logic [CART_AW-1:0] WIN_HI   = CART_AW'(32'h0801_0000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    input  logic               remap_en,
    input  logic               idle,
    input  logic               copy_last,
    input  logic [DRAM_AW-1:0] end_dram,
    input  logic [CART_AW-1:0] end_cart,
    output logic               start_o,
    output logic               to_cart_o,
    output logic [LEN_W-1:0]   len_o,
    output logic [DRAM_AW-1:0] dram_q_o,
    output logic [CART_AW-1:0] cart_q_o,
    output logic [CART_AW-1:0] start_cart_o
);

    localparam logic [DRAM_AW-1:0] ALIGN_M = DRAM_AW'((1 << ALIGN_LG2) - 1);

    typedef struct packed {
        logic [DRAM_AW-1:0] dram;
        logic [CART_AW-1:0] cart;
    } regs_t;

    regs_t regs_d, regs_q;

    reg_sel_e           sel;
    logic [DRAM_AW-1:0] dram_sum;
    logic [DRAM_AW-1:0] dram_round;
    logic [CART_AW-1:0] cart_even;
    logic               in_win;

    assign sel        = reg_sel_e'(reg_sel);
    assign dram_sum   = end_dram + ALIGN_M;
    assign dram_round = dram_sum & ~ALIGN_M;
    assign cart_even  = end_cart + CART_AW'(end_cart[0]);
    assign in_win     = remap_en && (regs_q.cart >= WIN_LO) && (regs_q.cart < WIN_HI);

    // Save-window spread: offset bits doubled and placed above the base
    always_comb begin
        if (in_win)
            start_cart_o = WIN_LO | (CART_AW'(regs_q.cart[WIN_OFS_W-1:0]) << 1);
        else
            start_cart_o = regs_q.cart;
    end

    always_comb begin
        regs_d    = regs_q;
        start_o   = 1'b0;
        to_cart_o = 1'b0;
        len_o     = reg_wdata[LEN_W-1:0];
        if (copy_last) begin
            regs_d.dram = dram_round;
            regs_d.cart = cart_even;
        end else if (reg_we && idle) begin
            case (sel)
                SEL_DRAM_ADDR: regs_d.dram = {reg_wdata[DRAM_AW-1:2], 2'b00};
                SEL_CART_ADDR: regs_d.cart = {reg_wdata[CART_AW-1:1], 1'b0};
                SEL_TO_CART: begin
                    start_o   = 1'b1;
                    to_cart_o = 1'b1;
                end
                SEL_TO_DRAM: start_o = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dram_q_o = regs_q.dram;
    assign cart_q_o = regs_q.cart;

endmodule

// File: rtl/cbus_dma_mover.sv
module cbus_dma_mover #(
    parameter int DRAM_AW = 24,
    parameter int CART_AW = 32,
    parameter int LEN_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               to_cart,
    input  logic [LEN_W-1:0]   len,
    input  logic [DRAM_AW-1:0] dram_start,
    input  logic [CART_AW-1:0] cart_start,
    input  logic [7:0]         dram_rd_data,
    input  logic [7:0]         cart_rd_data,
    output logic               active,
    output logic               copy_last,
    output logic [DRAM_AW-1:0] end_dram,
    output logic [CART_AW-1:0] end_cart,
    output logic [DRAM_AW-1:0] dram_rd_addr,
    output logic               dram_wr_en,
    output logic [DRAM_AW-1:0] dram_wr_addr,
    output logic [7:0]         dram_wr_data,
    output logic [CART_AW-1:0] cart_rd_addr,
    output logic               cart_wr_en,
    output logic [CART_AW-1:0] cart_wr_addr,
    output logic [7:0]         cart_wr_data
);

    typedef struct packed {
        logic               active;
        logic               to_cart;
        logic [LEN_W-1:0]   rem;
        logic [DRAM_AW-1:0] dptr;
        logic [CART_AW-1:0] cptr;
    } mv_t;

    mv_t mv_d, mv_q;

    always_comb begin
        mv_d = mv_q;
        if (start) begin
            mv_d.active  = 1'b1;
            mv_d.to_cart = to_cart;
            mv_d.rem     = len;
            mv_d.dptr    = dram_start;
            mv_d.cptr    = cart_start;
        end else if (mv_q.active) begin
            if (mv_q.rem == '0) begin
                mv_d.active = 1'b0;
            end else begin
                mv_d.rem  = mv_q.rem - 1'b1;
                mv_d.dptr = mv_q.dptr + 1'b1;
                mv_d.cptr = mv_q.cptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= mv_d;
    end

    assign active       = mv_q.active;
    assign copy_last    = mv_q.active && (mv_q.rem == '0);
    assign end_dram     = mv_q.dptr + 1'b1;
    assign end_cart     = mv_q.cptr + 1'b1;

    assign dram_rd_addr = mv_q.dptr;
    assign dram_wr_addr = mv_q.dptr;
    assign cart_rd_addr = mv_q.cptr;
    assign cart_wr_addr = mv_q.cptr;
    assign dram_wr_en   = mv_q.active && !mv_q.to_cart;
    assign cart_wr_en   = mv_q.active &&  mv_q.to_cart;
    assign dram_wr_data = cart_rd_data;
    assign cart_wr_data = dram_rd_data;

endmodule

// File: rtl/cbus_dma_timer.sv
module cbus_dma_timer #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat_in,
    input  logic             copy_last,
    output logic             waiting,
    output logic             done
);

    typedef struct packed {
        logic [LAT_W-1:0] lat;
        logic [LAT_W-1:0] cnt;
        logic             waiting;
        logic             done;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d      = tm_q;
        tm_d.done = 1'b0;
        if (start) tm_d.lat = lat_in;
        if (copy_last) begin
            tm_d.waiting = 1'b1;
            tm_d.cnt     = tm_q.lat;
        end else if (tm_q.waiting) begin
            if (tm_q.cnt == '0) begin
                tm_d.waiting = 1'b0;
                tm_d.done    = 1'b1;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign waiting = tm_q.waiting;
    assign done    = tm_q.done;

endmodule

// File: rtl/cbus_dma.sv
module cbus_dma #(
    parameter int DRAM_AW = 24,
    parameter int CART_AW = 32,
    parameter int LEN_W   = 24,
    parameter int LAT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    input  logic               flash_remap_en,
    input  logic [LAT_W-1:0]   lat_cycles,
    output logic [DRAM_AW-1:0] dram_rd_addr,
    input  logic [7:0]         dram_rd_data,
    output logic               dram_wr_en,
    output logic [DRAM_AW-1:0] dram_wr_addr,
    output logic [7:0]         dram_wr_data,
    output logic [CART_AW-1:0] cart_rd_addr,
    input  logic [7:0]         cart_rd_data,
    output logic               cart_wr_en,
    output logic [CART_AW-1:0] cart_wr_addr,
    output logic [7:0]         cart_wr_data,
    output logic               busy,
    output logic               done_irq,
    output logic [DRAM_AW-1:0] dram_addr_o,
    output logic [CART_AW-1:0] cart_addr_o
);

    logic               start, to_cart, active, copy_last, waiting;
    logic [LEN_W-1:0]   len;
    logic [DRAM_AW-1:0] end_dram;
    logic [CART_AW-1:0] end_cart, start_cart;

    assign busy = active | waiting;

    cbus_dma_regs #(
        .DRAM_AW (DRAM_AW),
        .CART_AW (CART_AW),
        .LEN_W   (LEN_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .remap_en     (flash_remap_en),
        .idle         (!busy),
        .copy_last    (copy_last),
        .end_dram     (end_dram),
        .end_cart     (end_cart),
        .start_o      (start),
        .to_cart_o    (to_cart),
        .len_o        (len),
        .dram_q_o     (dram_addr_o),
        .cart_q_o     (cart_addr_o),
        .start_cart_o (start_cart)
    );

    cbus_dma_mover #(
        .DRAM_AW (DRAM_AW),
        .CART_AW (CART_AW),
        .LEN_W   (LEN_W)
    ) u_mover (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .to_cart      (to_cart),
        .len          (len),
        .dram_start   (dram_addr_o),
        .cart_start   (start_cart),
        .dram_rd_data (dram_rd_data),
        .cart_rd_data (cart_rd_data),
        .active       (active),
        .copy_last    (copy_last),
        .end_dram     (end_dram),
        .end_cart     (end_cart),
        .dram_rd_addr (dram_rd_addr),
        .dram_wr_en   (dram_wr_en),
        .dram_wr_addr (dram_wr_addr),
        .dram_wr_data (dram_wr_data),
        .cart_rd_addr (cart_rd_addr),
        .cart_wr_en   (cart_wr_en),
        .cart_wr_addr (cart_wr_addr),
        .cart_wr_data (cart_wr_data)
    );

    cbus_dma_timer #(
        .LAT_W (LAT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lat_in    (lat_cycles),
        .copy_last (copy_last),
        .waiting   (waiting),
        .done      (done_irq)
    );

endmodule

// File: rtl/cbus_dma_chk.sv
module cbus_dma_chk #(
    parameter int DRAM_AW = 24,
    parameter int CART_AW = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done_irq,
    input logic               dram_wr_en,
    input logic               cart_wr_en,
    input logic [DRAM_AW-1:0] dram_wr_addr,
    input logic [CART_AW-1:0] cart_wr_addr,
    input logic [DRAM_AW-1:0] dram_addr_o,
    input logic [CART_AW-1:0] cart_addr_o
);

    a_r8_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !busy);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_irq);

    a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_wr_en && cart_wr_en));

    a_r10_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_wr_en || cart_wr_en) |-> busy);

    a_r3_cart_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_wr_en && $past(cart_wr_en)) |-> cart_wr_addr == $past(cart_wr_addr) + 1'b1);

    a_r4_dram_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_wr_en && $past(dram_wr_en)) |-> dram_wr_addr == $past(dram_wr_addr) + 1'b1);

    a_r5_dram_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> dram_addr_o[2:0] == 3'b000);

    a_r6_cart_even: assert property (@(posedge clk) disable iff (!rst_n)
        !cart_addr_o[0]);

endmodule

bind cbus_dma cbus_dma_chk #(
    .DRAM_AW (DRAM_AW),
    .CART_AW (CART_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done_irq     (done_irq),
    .dram_wr_en   (dram_wr_en),
    .cart_wr_en   (cart_wr_en),
    .dram_wr_addr (dram_wr_addr),
    .cart_wr_addr (cart_wr_addr),
    .dram_addr_o  (dram_addr_o),
    .cart_addr_o  (cart_addr_o)
);

// File: tb/cbus_dma_tb.sv
`timescale 1ns/1ps
module cbus_dma_tb;

    localparam int DAW = 16;
    localparam int CAW = 32;
    localparam int LW  = 8;
    localparam int TW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [1:0]     reg_sel = 2'd0;
    logic [31:0]    reg_wdata = '0;
    logic           flash_remap_en = 1'b0;
    logic [TW-1:0]  lat_cycles = '0;
    logic [DAW-1:0] dram_rd_addr, dram_wr_addr, dram_addr_o;
    logic [CAW-1:0] cart_rd_addr, cart_wr_addr, cart_addr_o;
    logic [7:0]     dram_rd_data, cart_rd_data, dram_wr_data, cart_wr_data;
    logic           dram_wr_en, cart_wr_en, busy, done_irq;

    always #4 clk = ~clk;

    function automatic logic [7:0] dpat(input logic [DAW-1:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] cpat(input logic [CAW-1:0] a);
        return a[7:0] ^ a[15:8] ^ (a[23:16] + a[31:24]) ^ 8'h3C;
    endfunction

    function automatic logic [CAW-1:0] remap(input logic [CAW-1:0] c, input logic en);
        if (en && c >= 32'h0800_0000 && c < 32'h0801_0000)
            return 32'h0800_0000 | ({12'd0, c[19:0]} << 1);
        return c;
    endfunction

    assign dram_rd_data = dpat(dram_rd_addr);
    assign cart_rd_data = cpat(cart_rd_addr);

    cbus_dma #(.DRAM_AW(DAW), .CART_AW(CAW), .LEN_W(LW), .LAT_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .flash_remap_en(flash_remap_en), .lat_cycles(lat_cycles),
        .dram_rd_addr(dram_rd_addr), .dram_rd_data(dram_rd_data), .dram_wr_en(dram_wr_en),
        .dram_wr_addr(dram_wr_addr), .dram_wr_data(dram_wr_data),
        .cart_rd_addr(cart_rd_addr), .cart_rd_data(cart_rd_data), .cart_wr_en(cart_wr_en),
        .cart_wr_addr(cart_wr_addr), .cart_wr_data(cart_wr_data),
        .busy(busy), .done_irq(done_irq), .dram_addr_o(dram_addr_o), .cart_addr_o(cart_addr_o)
    );

    // Expected copy context, written by the stimulus before each start
    logic [DAW-1:0] exp_d = '0;
    logic [CAW-1:0] exp_c = '0;
    logic           exp_to_cart = 1'b0;

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    int n_cart = 0, n_dram = 0, wcnt = 0;

    // Byte monitor: every write checked against the arithmetic model
    always @(negedge clk) begin
        if (!busy) begin
            wcnt = 0;
            if (dram_wr_en || cart_wr_en) begin
                m_chk++; m_fail++;
                $display("FAIL R10 write enable while idle: dram=%0b cart=%0b exp 0", dram_wr_en, cart_wr_en);
            end
        end else begin
            if (cart_wr_en) begin
                m_chk++;
                if (!exp_to_cart || dram_wr_en || cart_wr_addr != exp_c + CAW'(wcnt) ||
                    cart_wr_data != dpat(exp_d + DAW'(wcnt))) begin
                    m_fail++;
                    $display("FAIL R3 byte %0d: addr=%h data=%h exp addr=%h data=%h", wcnt,
                             cart_wr_addr, cart_wr_data, exp_c + CAW'(wcnt), dpat(exp_d + DAW'(wcnt)));
                end
                wcnt++; n_cart++;
            end
            if (dram_wr_en) begin
                m_chk++;
                if (exp_to_cart || dram_wr_addr != exp_d + DAW'(wcnt) ||
                    dram_wr_data != cpat(exp_c + CAW'(wcnt))) begin
                    m_fail++;
                    $display("FAIL R4 byte %0d: addr=%h data=%h exp addr=%h data=%h", wcnt,
                             dram_wr_addr, dram_wr_data, exp_d + DAW'(wcnt), cpat(exp_c + CAW'(wcnt)));
                end
                wcnt++; n_dram++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_sel = sel; reg_wdata = data; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic xfer(input bit to_cart, input logic [31:0] d, input logic [31:0] c,
                        input int len, input int lat, input bit fl);
        int nb, cyc, c0, d0;
        logic [DAW-1:0] ed;
        logic [CAW-1:0] ec;
        nb = len + 1;
        wr(2'd0, d);
        check(dram_addr_o == (d[DAW-1:0] & 16'hFFFC), "R2 dram addr", dram_addr_o, d[DAW-1:0] & 16'hFFFC);
        wr(2'd1, c);
        check(cart_addr_o == (c & 32'hFFFF_FFFE), "R2 cart addr", cart_addr_o, c & 32'hFFFF_FFFE);
        exp_d = d[DAW-1:0] & 16'hFFFC;
        exp_c = remap(c & 32'hFFFF_FFFE, fl);
        exp_to_cart = to_cart;
        flash_remap_en = fl;
        lat_cycles = TW'(lat);
        c0 = n_cart; d0 = n_dram;
        wr(to_cart ? 2'd2 : 2'd3, 32'hAB00_0000 | 32'(len));
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        cyc = 0;
        while (!done_irq && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == nb + lat + 1, "R8 completion cycle", cyc, nb + lat + 1);
        check(busy == 1'b0, "R8 busy low at done", busy, 0);
        check(n_cart - c0 == (to_cart ? nb : 0), to_cart ? "R3 byte count" : "R10 cart idle",
              n_cart - c0, to_cart ? nb : 0);
        check(n_dram - d0 == (to_cart ? 0 : nb), to_cart ? "R10 dram idle" : "R4 byte count",
              n_dram - d0, to_cart ? 0 : nb);
        ed = (exp_d + DAW'(nb) + 16'd7) & 16'hFFF8;
        ec = exp_c + CAW'(nb);
        ec = ec + CAW'(ec[0]);
        check(dram_addr_o == ed, "R5 dram realign", dram_addr_o, ed);
        check(cart_addr_o == ec, fl ? "R7 remapped end" : "R6 cart realign", cart_addr_o, ec);
        @(negedge clk);
        check(done_irq == 1'b0, "R8 pulse width", done_irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk + 1, n_fail + m_fail + 1);
        $finish;
    end

    initial begin
        int lens[9] = '{0, 1, 2, 3, 6, 7, 8, 15, 40};
        logic [31:0] drs[4] = '{32'h0000, 32'h0004, 32'h0123, 32'hFFF8};
        logic [31:0] crs[4] = '{32'h1000_0000, 32'h1000_0001, 32'h1000_0006, 32'hFFFF_FFF0};
        int lats[4] = '{0, 1, 5, 15};
        logic [31:0] fl_c[5] = '{32'h0800_0000, 32'h0800_0102, 32'h0800_FFFE, 32'h0801_0000, 32'h07FF_FFFE};
        int c0, d0, cyc;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done_irq == 0, "R1 reset flags", {busy, done_irq}, 0);
        check(dram_wr_en == 0 && cart_wr_en == 0, "R1 reset enables", {dram_wr_en, cart_wr_en}, 0);
        check(dram_addr_o == 0 && cart_addr_o == 0, "R1 reset addresses", cart_addr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: both directions, lengths, DRAM/cart starts and latencies (R3 R4 R5 R6 R8)
        for (int dir = 0; dir < 2; dir++)
            for (int li = 0; li < 9; li++)
                for (int di = 0; di < 4; di++)
                    for (int ci = 0; ci < 4; ci++)
                        for (int ti = 0; ti < 4; ti++)
                            xfer(dir == 1, drs[di], crs[ci], lens[li], lats[ti], 1'b0);

        // R7 save-window remap, on and just outside the window, both directions
        for (int dir = 0; dir < 2; dir++) begin
            for (int k = 0; k < 5; k++) xfer(dir == 1, 32'h0040, fl_c[k], 3, 2, 1'b1);
            xfer(dir == 1, 32'h0040, 32'h0800_0102, 3, 2, 1'b0);
        end

        // R9 writes during busy ignored; R8 latency sampled at start
        wr(2'd0, 32'h0100);
        wr(2'd1, 32'h2000_0000);
        exp_d = 16'h0100; exp_c = 32'h2000_0000; exp_to_cart = 1'b1;
        flash_remap_en = 1'b0; lat_cycles = 4'd3;
        c0 = n_cart; d0 = n_dram;
        wr(2'd2, 32'd5);
        lat_cycles = 4'd9;
        wr(2'd3, 32'd2);
        wr(2'd0, 32'h4444);
        wr(2'd1, 32'h3000_0000);
        wr(2'd2, 32'd1);
        cyc = 4;
        while (!done_irq && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 10, "R8 latency sampled at start", cyc, 10);
        check(n_cart - c0 == 6, "R9 no restart cart bytes", n_cart - c0, 6);
        check(n_dram - d0 == 0, "R9 no extra direction", n_dram - d0, 0);
        check(dram_addr_o == 16'h0108, "R9 dram addr kept", dram_addr_o, 16'h0108);
        check(cart_addr_o == 32'h2000_0006, "R9 cart addr kept", cart_addr_o, 32'h2000_0006);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(!busy && !done_irq, "R9 stays idle", {busy, done_irq}, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

endmodule